// File: doc/BRIEF.md
# Phase-Tap Clock Output Pair

This block produces two identical clock outputs from a sampling clock that runs at sixteen times the output frequency. A free-running phase counter of `PH_W` bits (sixteen steps by default) defines one output period. Each step of the counter is one time unit, so the output phase can be placed anywhere on a 1/16-cycle grid.

A six-bit control word carries three three-level digits that choose the output's shape: a signed phase shift of up to seven time units, an inverted copy of the reference, the reference divided by two or by four, or a forced stop. An edge-select input picks whether the outputs follow the rising or the falling reference edge and also sets the level at which stopped outputs rest. A gate input stops the pair cleanly unless the pair is strapped as the loop's feedback pair. A test input swaps the internal phase counter for an external reference that is sampled into a short delay line, and the chosen shift still applies.

Top module: `tap_pair`

## Requirements
- R1: `q0` and `q1` carry the same value in every cycle.
- R2: After reset is released, with the zero-skew code (all digits MID) and `edge_rise` high, the outputs are high for eight cycles and then low for eight cycles. The first high cycle follows the first clock edge after release, where the phase counter reads 0.
- R3: Digits are packed as `ctrl_code[5:4]`=F2, `[3:2]`=F1, `[1:0]`=F0, with LOW=00, MID=01 and HIGH=10. Let v = 9*F2+3*F1+F0. A v from 6 to 20 selects a shift of v-13 time units, and a positive shift delays the waveform by that many sampling cycles.
- R4: A digit value of 11, and the v values 1 to 5 and 24 to 26, act as zero skew.
- R5: With `edge_rise` low, the phase reference is inverted, so the output is low in phases 0 to 7 before any shift.
- R6: v=21 gives the complement of the zero-skew waveform.
- R7: v=22 divides by two and v=23 divides by four. Both change state only at phase 0, both rise together, and their count restarts at zero whenever a new code is taken up.
- R8: v=0 holds the outputs at `!edge_rise` whatever the gate does.
- R9: With `gate_stop` high and `fb_pair` low, the outputs settle at `!edge_rise`. Stopping and restarting happen only when the running waveform is already at that level, so no pulse is shorter than the selected waveform's own. With `fb_pair` high the gate has no effect.
- R10: A change to `ctrl_code` takes effect at the next phase-counter wrap, so the old shape continues until the cycle in which the counter reads 0.
- R11: With `test_mode` high, the output equals `test_ref` as it was sampled 8+s clock edges earlier, where s is the selected shift. A new code is taken up on each sampled rising edge of `test_ref`.
- R12: While reset is held, the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 16x the output frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_code | input | 6 | Three two-bit three-level digits F2,F1,F0 |
| edge_rise | input | 1 | 1: follow rising reference edge, stop low; 0: falling, stop high |
| gate_stop | input | 1 | 1 requests a synchronous stop of the pair |
| fb_pair | input | 1 | Strap: the pair drives the feedback path and ignores the gate |
| test_mode | input | 1 | 1 replaces the phase counter with `test_ref` |
| test_ref | input | 1 | Bypass reference sampled in test mode |
| q0 | output | 1 | Clock output, first of the pair |
| q1 | output | 1 | Clock output, second of the pair |

## Verification
The hold-level checks assume that `edge_rise` and `ctrl_code` stay put while they count, that `test_mode` is low, and that `fb_pair` behaves as a static strap. A change to any of these restarts the count. The stimulus changes the edge select only while the runt monitor is paused. It holds each code for several full periods before sampling, and it drives `test_ref` only while the pair is in test mode. The sweeps cover every valid code and two codes with an illegal digit under both edge selections. The expected waveform is rebuilt from the phase arithmetic, counted from the release of reset.

// File: rtl/tap_pair_pkg.sv
`timescale 1ns/1ps
// Shared types and the control-code decoder for the phase-tap output pair.
// Assumes three digits, each of them LOW=00, MID=01 or HIGH=10; the value 11 is illegal.
package tap_pair_pkg;
    localparam int MAX_SKEW = 7;
    localparam int SKEW_W   = 4;
    localparam int DL_LEN   = 2 * MAX_SKEW + 1;
    localparam int ZERO_IDX = 13;
    localparam logic [1:0] DIG_LO = 2'b00;
    localparam logic [1:0] DIG_MD = 2'b01;
    localparam logic [1:0] DIG_HI = 2'b10;
    localparam logic [5:0] CODE_ZERO = {DIG_MD, DIG_MD, DIG_MD};

    typedef enum logic [2:0] {
        MODE_SHIFT, MODE_INV, MODE_DIV2, MODE_DIV4, MODE_OFF
    } mode_e;

    typedef struct packed {
        mode_e                    mode;
        logic signed [SKEW_W-1:0] skew;
    } tap_cfg_t;

    localparam tap_cfg_t CFG_ZERO = '{mode: MODE_SHIFT, skew: '0};

    // Map a three-digit code to a mode; reserved or illegal codes give zero skew.
    function automatic tap_cfg_t decode_code(input logic [5:0] code);
        tap_cfg_t r;
        int       v;
        r = CFG_ZERO;
        if (code[5:4] != 2'b11 && code[3:2] != 2'b11 && code[1:0] != 2'b11) begin
            v = int'(code[5:4]) * 9 + int'(code[3:2]) * 3 + int'(code[1:0]);
            if (v == 0)
                r.mode = MODE_OFF;
            else if (v >= ZERO_IDX - MAX_SKEW && v <= ZERO_IDX + MAX_SKEW)
                r.skew = SKEW_W'(v - ZERO_IDX);
            else if (v == ZERO_IDX + MAX_SKEW + 1)
                r.mode = MODE_INV;
            else if (v == ZERO_IDX + MAX_SKEW + 2)
                r.mode = MODE_DIV2;
            else if (v == ZERO_IDX + MAX_SKEW + 3)
                r.mode = MODE_DIV4;
        end
        return r;
    endfunction
endpackage

// File: rtl/tap_timebase.sv
`timescale 1ns/1ps
// Phase counter, bypass delay line, divider count and registered configuration.
// A new code is taken up on a reference tick: a counter wrap, or in test mode a
// sampled rising edge of the bypass reference. The divider restarts when the code changes.
module tap_timebase
    import tap_pair_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              test_ref,
    input  logic [5:0]        code,
    output logic [PH_W-1:0]   phase,
    output logic [1:0]        div_cnt,
    output logic [DL_LEN-1:0] ref_hist,
    output tap_cfg_t          cfg
);
    logic [5:0] code_q;
    logic       tick;

    // Reference tick: end of a counter period, or a sampled bypass rising edge.
    always_comb tick = test_mode ? (ref_hist[0] & ~ref_hist[1]) : (phase == '1);

    // Free-running phase counter; one wrap is one output period.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    // Delay line holding the most recent samples of the bypass reference.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_hist <= '0;
        else        ref_hist <= {ref_hist[DL_LEN-2:0], test_ref};
    end

    // Take up the code on a tick, and restart the divider when the code differs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= CFG_ZERO;
            code_q  <= CODE_ZERO;
            div_cnt <= '0;
        end else if (tick) begin
            cfg     <= decode_code(code);
            code_q  <= code;
            div_cnt <= (code != code_q) ? 2'd0 : div_cnt + 2'd1;
        end
    end
endmodule

// File: rtl/tap_wave.sv
`timescale 1ns/1ps
// Combinational waveform selector: a shifted, inverted, divided or stopped level.
// Assumes the period is at least 2*MAX_SKEW+2 phases, so that a shift never aliases.
module tap_wave
    import tap_pair_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic [PH_W-1:0]   phase,
    input  logic [1:0]        div_cnt,
    input  logic [DL_LEN-1:0] ref_hist,
    input  tap_cfg_t          cfg,
    input  logic              edge_rise,
    input  logic              test_mode,
    output logic              wave
);
    logic [PH_W-1:0] idx;
    logic [4:0]      tap;
    logic            base;
    logic            ref_lvl;

    // Locate the shifted sample, from the counter or from the delay line.
    always_comb begin
        idx  = phase - PH_W'(cfg.skew);
        tap  = 5'(MAX_SKEW) + 5'(cfg.skew);
        base = test_mode ? ref_hist[tap] : ~idx[PH_W-1];
        ref_lvl = edge_rise ? base : ~base;
    end

    // Pick the output shape from the active mode.
    always_comb begin
        unique case (cfg.mode)
            MODE_INV:  wave = ~ref_lvl;
            MODE_DIV2: wave = ~div_cnt[0];
            MODE_DIV4: wave = ~div_cnt[1];
            MODE_OFF:  wave = ~edge_rise;
            default:   wave = ref_lvl;
        endcase
    end
endmodule

// File: rtl/tap_gate.sv
`timescale 1ns/1ps
// Synchronous stop/restart and output register. The run state changes only while
// the waveform sits at the stop level, so a stop or restart can leave no runt pulse.
module tap_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wave,
    input  logic edge_rise,
    input  logic gate_stop,
    input  logic fb_pair,
    output logic clk_out
);
    logic run_q;
    logic run_nx;
    logic stop_lvl;

    // Next run state, allowed to move only at the stop level.
    always_comb begin
        stop_lvl = ~edge_rise;
        run_nx   = (wave == stop_lvl) ? (~gate_stop | fb_pair) : run_q;
    end

    // Register the run state and the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b1;
            clk_out <= 1'b0;
        end else begin
            run_q   <= run_nx;
            clk_out <= run_nx ? wave : stop_lvl;
        end
    end
endmodule

// File: rtl/tap_pair.sv
`timescale 1ns/1ps
// One programmable phase-tap clock output pair, driven by a 2**PH_W times
// oversampling clock. Both outputs come from a single register and so always match.
module tap_pair
    import tap_pair_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] ctrl_code,
    input  logic       edge_rise,
    input  logic       gate_stop,
    input  logic       fb_pair,
    input  logic       test_mode,
    input  logic       test_ref,
    output logic       q0,
    output logic       q1
);
    logic [PH_W-1:0]   phase;
    logic [1:0]        div_cnt;
    logic [DL_LEN-1:0] ref_hist;
    tap_cfg_t          cfg;
    logic              wave;
    logic              pair_q;

    tap_timebase #(.PH_W(PH_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .test_ref(test_ref),
        .code(ctrl_code), .phase(phase), .div_cnt(div_cnt),
        .ref_hist(ref_hist), .cfg(cfg)
    );

    tap_wave #(.PH_W(PH_W)) u_wave (
        .phase(phase), .div_cnt(div_cnt), .ref_hist(ref_hist), .cfg(cfg),
        .edge_rise(edge_rise), .test_mode(test_mode), .wave(wave)
    );

    tap_gate u_gate (
        .clk(clk), .rst_n(rst_n), .wave(wave), .edge_rise(edge_rise),
        .gate_stop(gate_stop), .fb_pair(fb_pair), .clk_out(pair_q)
    );

    // Both outputs of the pair come from the same register.
    always_comb begin
        q0 = pair_q;
        q1 = pair_q;
    end
endmodule

// File: rtl/tap_pair_chk.sv
`timescale 1ns/1ps
// Checker for tap_pair. The hold windows are counted in registers, so that no
// deep $past is needed.
module tap_pair_chk #(
    parameter int PH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            q0,
    input logic            q1,
    input logic [5:0]      ctrl_code,
    input logic            edge_rise,
    input logic            gate_stop,
    input logic            fb_pair,
    input logic            test_mode,
    input logic [PH_W-1:0] phase
);
    localparam int PERIOD   = 2 ** PH_W;
    localparam int HOLD_LIM = 4 * PERIOD + 4;
    localparam int HW       = $clog2(HOLD_LIM + 1);

    logic [HW-1:0] gate_hold;
    logic [HW-1:0] off_hold;
    logic [5:0]    code_q;
    logic          er_q;
    logic          steady;

    always_comb steady = (code_q == ctrl_code) && (er_q == edge_rise) && !test_mode;

    // Count how long a stop request, or the disable code, has been held steady.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hold <= '0;
            off_hold  <= '0;
            code_q    <= '0;
            er_q      <= 1'b0;
        end else begin
            code_q <= ctrl_code;
            er_q   <= edge_rise;
            if (steady && gate_stop && !fb_pair)
                gate_hold <= (gate_hold == HW'(HOLD_LIM)) ? gate_hold : gate_hold + 1'b1;
            else
                gate_hold <= '0;
            if (steady && ctrl_code == 6'b000000)
                off_hold <= (off_hold == HW'(HOLD_LIM)) ? off_hold : off_hold + 1'b1;
            else
                off_hold <= '0;
        end
    end

    assert_pair_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q0 == q1);

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> phase == PH_W'($past(phase) + 1'b1));

    assert_disable_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (off_hold == HW'(HOLD_LIM)) |-> q0 == !edge_rise);

    assert_gate_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hold == HW'(HOLD_LIM)) |-> q0 == !edge_rise);
endmodule

bind tap_pair tap_pair_chk #(.PH_W(PH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .q0(q0), .q1(q1), .ctrl_code(ctrl_code),
    .edge_rise(edge_rise), .gate_stop(gate_stop), .fb_pair(fb_pair),
    .test_mode(test_mode), .phase(phase)
);

// File: tb/tap_pair_test.sv
`timescale 1ns/1ps
module tap_pair_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ctrl_code = 6'b010101;
    logic       edge_rise = 1'b1;
    logic       gate_stop = 1'b0;
    logic       fb_pair = 1'b0;
    logic       test_mode = 1'b0;
    logic       test_ref = 1'b0;
    logic       q0, q1;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [31:0] tb_hist = '0;
    logic mon_en = 1'b0;
    logic mon_prev = 1'b0;
    int   runlen = 100;

    tap_pair uut (
        .clk(clk), .rst_n(rst_n), .ctrl_code(ctrl_code), .edge_rise(edge_rise),
        .gate_stop(gate_stop), .fb_pair(fb_pair), .test_mode(test_mode),
        .test_ref(test_ref), .q0(q0), .q1(q1)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
        tb_hist <= {tb_hist[30:0], test_ref};
    end

    // Runt monitor for R9: every run of equal output values lasts at least 8 cycles.
    always @(negedge clk) begin
        if (!mon_en) runlen = 100;
        else if (q0 !== mon_prev) begin
            n_cmp++;
            if (runlen < 8) begin
                n_bad++;
                $display("FAIL R9 runt: run of %0d cycles, expected >= 8", runlen);
            end
            runlen = 1;
        end else runlen++;
        mon_prev = q0;
    end

    function automatic void model(input logic [5:0] c, output int md, output int sk);
        int d2, d1, d0, v;
        d2 = int'(c[5:4]); d1 = int'(c[3:2]); d0 = int'(c[1:0]);
        md = 0; sk = 0;
        if (d2 < 3 && d1 < 3 && d0 < 3) begin
            v = d2 * 9 + d1 * 3 + d0;
            if (v == 0) md = 4;
            else if (v >= 6 && v <= 20) sk = v - 13;
            else if (v == 21) md = 1;
            else if (v == 22) md = 2;
            else if (v == 23) md = 3;
        end
    endfunction

    function automatic logic expv(input int m, input int ld, input logic e, input logic [5:0] c);
        int md, sk, p, idx, cn;
        logic b;
        model(c, md, sk);
        p = (m - 1) % 16;
        idx = (p - sk + 16) % 16;
        b = (idx < 8);
        if (!e) b = !b;
        cn = ((m - 1 - ld) / 16) % 4;
        case (md)
            1: b = !b;
            2: b = (cn % 2) == 0;
            3: b = cn < 2;
            4: b = !e;
            default: ;
        endcase
        return b;
    endfunction

    function automatic string tagof(input logic [5:0] c, input logic e);
        int md, sk;
        model(c, md, sk);
        if (c[5:4] == 2'b11 || c[3:2] == 2'b11 || c[1:0] == 2'b11) return "R4";
        if (md == 4) return "R8";
        if (md == 1) return "R6";
        if (md >= 2) return "R7";
        if (!e) return "R5";
        if (sk == 0 && c != 6'b010101) return "R4";
        return "R3";
    endfunction

    task automatic chk(input logic exp, input string req);
        n_cmp++;
        if (q0 !== exp) begin
            n_bad++;
            $display("FAIL %s: q0=%b expected %b at edge %0d", req, q0, exp, cyc);
        end
        n_cmp++;
        if (q1 !== q0) begin
            n_bad++;
            $display("FAIL R1: q1=%b expected %b at edge %0d", q1, q0, cyc);
        end
    endtask

    task automatic run_code(input logic [5:0] c, input logic e, input int ncheck);
        int ld;
        ctrl_code = c;
        edge_rise = e;
        ld = (cyc / 16 + 1) * 16;
        while (cyc < ld + 1) @(negedge clk);
        for (int k = 0; k < ncheck; k++) begin
            chk(expv(cyc, ld, e, c), tagof(c, e));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int ld;
        int sk;
        int md;
        repeat (4) @(negedge clk);
        chk(1'b0, "R12");
        rst_n = 1'b1;
        @(negedge clk);
        // R2: zero skew straight after reset, counted from release
        for (int k = 0; k < 32; k++) begin
            chk(expv(cyc, 0, 1'b1, 6'b010101), "R2");
            @(negedge clk);
        end
        // Sweep every code under both edge selections (R3-R8)
        for (int ei = 1; ei >= 0; ei--) begin
            for (int v = 0; v < 27; v++)
                run_code({2'(v / 9), 2'((v / 3) % 3), 2'(v % 3)}, 1'(ei), 64);
            run_code(6'b110101, 1'(ei), 32);
            run_code(6'b011101, 1'(ei), 32);
        end
        // R10: a code change waits for the next wrap
        run_code(6'b010101, 1'b1, 16);
        while (cyc % 16 != 5) @(negedge clk);
        ctrl_code = 6'b100100;
        ld = (cyc / 16 + 1) * 16;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (cyc <= ld) chk(expv(cyc, 0, 1'b1, 6'b010101), "R10");
            else           chk(expv(cyc, ld, 1'b1, 6'b100100), "R10");
        end
        // R9: stop and restart at several offsets, no runts
        run_code(6'b010101, 1'b1, 16);
        mon_en = 1'b1;
        for (int d = 3; d < 16; d += 4) begin
            repeat (d) @(negedge clk);
            gate_stop = 1'b1;
            repeat (24) @(negedge clk);
            for (int k = 0; k < 8; k++) begin chk(1'b0, "R9"); @(negedge clk); end
            gate_stop = 1'b0;
            repeat (20 + d) @(negedge clk);
        end
        // R9: the feedback pair ignores the gate
        fb_pair = 1'b1;
        gate_stop = 1'b1;
        for (int k = 0; k < 32; k++) begin
            chk(expv(cyc, 0, 1'b1, 6'b010101), "R9");
            @(negedge clk);
        end
        fb_pair = 1'b0;
        gate_stop = 1'b0;
        mon_en = 1'b0;
        edge_rise = 1'b0;
        repeat (20) @(negedge clk);
        mon_en = 1'b1;
        gate_stop = 1'b1;
        repeat (24) @(negedge clk);
        for (int k = 0; k < 8; k++) begin chk(1'b1, "R9"); @(negedge clk); end
        gate_stop = 1'b0;
        repeat (24) @(negedge clk);
        mon_en = 1'b0;
        // R8: disable holds the stop level with the gate open or closed
        ctrl_code = 6'b000000;
        repeat (20) @(negedge clk);
        for (int k = 0; k < 8; k++) begin chk(1'b1, "R8"); @(negedge clk); end
        gate_stop = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 8; k++) begin chk(1'b1, "R8"); @(negedge clk); end
        gate_stop = 1'b0;
        // R11: bypass reference through the delay line
        edge_rise = 1'b1;
        test_mode = 1'b1;
        for (int t = 0; t < 2; t++) begin
            ctrl_code = (t == 0) ? 6'b011001 : 6'b010000;
            model(ctrl_code, md, sk);
            for (int k = 0; k < 90; k++) begin
                if (k >= 40) chk(tb_hist[8 + sk], "R11");
                test_ref = 1'(((cyc / 3) % 2) ^ ((cyc / 7) % 2));
                @(negedge clk);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule